// File: doc/BRIEF.md
# PTP Offset Servo with Lock Detection

This block closes the frequency loop of a network-disciplined wallclock. Each time the time-transfer logic measures how far the local clock sits from the master, it presents a signed nanosecond offset with a one-cycle strobe and the current log2 message interval. The servo smooths the offsets with a power-of-two moving average. A proportional-integral loop then turns the smoothed value into a signed frequency correction in parts per billion, which feeds the wallclock's rate adjuster.

A locked flag with hysteresis reports when the loop has converged. The flag sets at a tight threshold and clears only at a much wider one, so jitter near a single threshold cannot make it chatter. The gains and the averaging depth come either from elaboration-time parameters or from run-time inputs, chosen by a parameter. The correction and the integrator both saturate, so a large initial step cannot wind up the loop.

Top module: `ofs_pi_servo`

## Requirements
- R1: After reset, freq_ppb_o, filt_ns_o, upd_o and locked_o are all zero.
- R2: The filtered offset is the sum of the last 2^L accepted samples, arithmetically shifted right by L (rounding toward minus infinity). Samples not yet seen since reset or a clear count as zero. L comes from avg_log2_i in the run-time variant, limited to AVG_LMAX, and from AVG_LOG2 in the fixed variant.
- R3: The edge that samples ofs_stb_i high is followed two edges later by a one-cycle upd_o pulse. freq_ppb_o, filt_ns_o and locked_o change only at that edge.
- R4: With avg the filtered offset and s(x) = x shifted left by n for a clamped interval n >= 0, or arithmetically right by -n for n < 0, the update computes p = s(avg*KP) >>> FRAC_SH and i = s(avg*KI) >>> FRAC_SH. The integrator becomes I + i and the output becomes p + I. The interval is the one captured with the strobe, and the gains are the ones present at the update edge.
- R5: Both the integrator and freq_ppb_o are saturated to +/-LIM_PPB (500000 by default) at every update.
- R6: At an update while unlocked, locked_o sets when |filtered offset| < LOCK_NS (500 ns).
- R7: While locked, locked_o clears only at an update with |filtered offset| > UNLOCK_NS (5000 ns). Values between the two thresholds keep the current state.
- R8: With RUNTIME_CFG = 0, kp_i, ki_i and avg_log2_i have no effect. The parameters KP, KI and AVG_LOG2 are used instead.
- R9: In the run-time variant, a change of avg_log2_i clears the filter history on the next edge.
- R10: Asserting rst_ni low at any time clears the integrator, the filter history and the lock flag.
- R11: log_intv_i (8-bit two's complement) is clamped to +/-IV_MAX (7) before it scales the gains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ofs_stb_i | input | 1 | One-cycle strobe marking a new offset sample |
| ofs_ns_i | input | OFS_W | Signed offset from master in ns |
| log_intv_i | input | 8 | Signed log2 of the message interval |
| kp_i | input | GAIN_W | Run-time proportional gain, unsigned, FRAC_SH fraction bits |
| ki_i | input | GAIN_W | Run-time integral gain, unsigned, FRAC_SH fraction bits |
| avg_log2_i | input | $clog2(AVG_LMAX+1) | Run-time log2 of the averaging depth |
| freq_ppb_o | output | PPB_W | Signed frequency correction in ppb |
| upd_o | output | 1 | Pulses when the outputs have been updated |
| locked_o | output | 1 | Lock flag with hysteresis |
| filt_ns_o | output | OFS_W | Filtered offset used by the last update |

## Verification
The embedded properties watch on every cycle that the integrator and the correction stay inside the saturation band. They also check that the outputs and the lock flag hold still between updates, that every strobe yields an update two edges later, that a clear empties the filter, and that each lock transition is backed by a filtered magnitude on the correct side of its threshold. Only the bench scenarios show the exact arithmetic: floor rounding of the average and of the shifted gain products, interval clamping, the switch from proportional to integral action, the fixed variant ignoring its configuration inputs, and a reset in the middle of a run erasing history.

// File: rtl/servo_pkg.sv
package servo_pkg;
   // Symmetric saturation of a 64-bit signed value.
   function automatic logic signed [63:0] sat_sym(input logic signed [63:0] v,
                                                  input logic signed [63:0] lim);
      if (v > lim)  return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction
endpackage

// File: rtl/ofs_avg_filter.sv
module ofs_avg_filter #(
   parameter int OFS_W = 32,
   parameter int LMAX  = 4,
   localparam int LW    = $clog2(LMAX + 1),
   localparam int DEPTH = 1 << LMAX,
   localparam int SUM_W = OFS_W + LMAX
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    clr_i,
   input  logic                    stb_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   input  logic [LW-1:0]           lg_i,
   output logic signed [OFS_W-1:0] avg_o
);
   logic signed [OFS_W-1:0] hist_q [DEPTH];
   logic signed [SUM_W-1:0] sum_q;
   logic [LMAX:0]           span;
   logic [LMAX-1:0]         old_idx;
   logic signed [SUM_W-1:0] ofs_x, old_x;

   always_comb begin
      span    = (LMAX+1)'(1) << lg_i;
      old_idx = LMAX'(span - (LMAX+1)'(1));
      ofs_x   = {{LMAX{ofs_i[OFS_W-1]}}, ofs_i};
      old_x   = {{LMAX{hist_q[old_idx][OFS_W-1]}}, hist_q[old_idx]};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
         sum_q <= '0;
      end else if (clr_i) begin
         for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
         sum_q <= '0;
      end else if (stb_i) begin
         hist_q[0] <= ofs_i;
         for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
         sum_q <= sum_q + ofs_x - old_x;
      end
   end

   assign avg_o = OFS_W'(sum_q >>> lg_i);

   // R9
   filt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (avg_o == '0));
endmodule

// File: rtl/pi_core.sv
module pi_core #(
   parameter int OFS_W   = 32,
   parameter int PPB_W   = 32,
   parameter int GAIN_W  = 16,
   parameter int FRAC_SH = 8,
   parameter int IV_MAX  = 7,
   parameter int LIM_PPB = 500000,
   localparam int IV_W   = $clog2(IV_MAX + 1) + 1,
   localparam int PW     = OFS_W + GAIN_W + 1 + IV_MAX
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    go_i,
   input  logic signed [OFS_W-1:0] avg_i,
   input  logic signed [IV_W-1:0]  iv_i,
   input  logic [GAIN_W-1:0]       kp_i,
   input  logic [GAIN_W-1:0]       ki_i,
   output logic signed [PPB_W-1:0] ppb_o
);
   import servo_pkg::*;

   localparam logic signed [63:0]      LIM64 = 64'(LIM_PPB);
   localparam logic signed [PPB_W-1:0] LIMP  = PPB_W'(LIM_PPB);

   logic signed [PW-1:0]    avg_x, kp_x, ki_x, prod_p, prod_i, term_p, term_i;
   logic [IV_W-1:0]         sh_l, sh_r;
   logic signed [63:0]      p64, i64, integ64, integ_n, out_n;
   logic signed [PPB_W-1:0] integ_q;

   always_comb begin
      avg_x   = {{(PW-OFS_W){avg_i[OFS_W-1]}}, avg_i};
      kp_x    = {{(PW-GAIN_W){1'b0}}, kp_i};
      ki_x    = {{(PW-GAIN_W){1'b0}}, ki_i};
      prod_p  = avg_x * kp_x;
      prod_i  = avg_x * ki_x;
      sh_l    = iv_i[IV_W-1] ? '0 : $unsigned(iv_i);
      sh_r    = iv_i[IV_W-1] ? $unsigned(-iv_i) : '0;
      term_p  = ((prod_p <<< sh_l) >>> sh_r) >>> FRAC_SH;
      term_i  = ((prod_i <<< sh_l) >>> sh_r) >>> FRAC_SH;
      p64     = {{(64-PW){term_p[PW-1]}}, term_p};
      i64     = {{(64-PW){term_i[PW-1]}}, term_i};
      integ64 = {{(64-PPB_W){integ_q[PPB_W-1]}}, integ_q};
      integ_n = sat_sym(integ64 + i64, LIM64);
      out_n   = sat_sym(p64 + integ_n, LIM64);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         integ_q <= '0;
         ppb_o   <= '0;
      end else if (go_i) begin
         integ_q <= integ_n[PPB_W-1:0];
         ppb_o   <= out_n[PPB_W-1:0];
      end
   end

   // R5
   integ_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (integ_q <= LIMP) && (integ_q >= -LIMP));
   // R5
   ppb_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ppb_o <= LIMP) && (ppb_o >= -LIMP));
   // R3
   ppb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !go_i |=> $stable(ppb_o));
endmodule

// File: rtl/lock_det.sv
module lock_det #(
   parameter int OFS_W     = 32,
   parameter int LOCK_NS   = 500,
   parameter int UNLOCK_NS = 5000
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    go_i,
   input  logic signed [OFS_W-1:0] avg_i,
   output logic                    locked_o
);
   localparam logic [OFS_W:0] LOCK_V   = (OFS_W+1)'(LOCK_NS);
   localparam logic [OFS_W:0] UNLOCK_V = (OFS_W+1)'(UNLOCK_NS);

   logic signed [OFS_W:0] avg_x;
   logic [OFS_W:0]        mag;

   always_comb begin
      avg_x = {avg_i[OFS_W-1], avg_i};
      mag   = avg_x[OFS_W] ? $unsigned(-avg_x) : $unsigned(avg_x);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               locked_o <= 1'b0;
      else if (go_i && !locked_o && mag < LOCK_V)   locked_o <= 1'b1;
      else if (go_i && locked_o && mag > UNLOCK_V)  locked_o <= 1'b0;
   end

   // R6
   lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_o) |-> ($past(go_i) && $past(mag) < LOCK_V));
   // R7
   lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(locked_o) |-> ($past(go_i) && $past(mag) > UNLOCK_V));
   // R7
   lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !go_i |=> $stable(locked_o));
endmodule

// File: rtl/ofs_pi_servo.sv
module ofs_pi_servo #(
   parameter int OFS_W       = 32,
   parameter int PPB_W       = 32,
   parameter int GAIN_W      = 16,
   parameter int FRAC_SH     = 8,
   parameter int AVG_LMAX    = 4,
   parameter int AVG_LOG2    = 3,
   parameter bit RUNTIME_CFG = 1'b1,
   parameter int KP          = 64,
   parameter int KI          = 16,
   parameter int IV_MAX      = 7,
   parameter int LIM_PPB     = 500000,
   parameter int LOCK_NS     = 500,
   parameter int UNLOCK_NS   = 5000,
   localparam int LW         = $clog2(AVG_LMAX + 1),
   localparam int IV_W       = $clog2(IV_MAX + 1) + 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    ofs_stb_i,
   input  logic signed [OFS_W-1:0] ofs_ns_i,
   input  logic signed [7:0]       log_intv_i,
   input  logic [GAIN_W-1:0]       kp_i,
   input  logic [GAIN_W-1:0]       ki_i,
   input  logic [LW-1:0]           avg_log2_i,
   output logic signed [PPB_W-1:0] freq_ppb_o,
   output logic                    upd_o,
   output logic                    locked_o,
   output logic signed [OFS_W-1:0] filt_ns_o
);
   localparam logic signed [7:0] IVP = 8'(IV_MAX);

   // elaboration checks
   if (AVG_LMAX < 1 || AVG_LOG2 > AVG_LMAX) begin : g_bad_depth
      $error("averaging depth parameters out of range");
   end
   if (LOCK_NS >= UNLOCK_NS) begin : g_bad_hyst
      $error("lock threshold must be below unlock threshold");
   end
   if (OFS_W + GAIN_W + 1 + IV_MAX >= 64) begin : g_bad_width
      $error("product width exceeds 63 bits");
   end
   if (IV_MAX < 1 || IV_MAX > 63) begin : g_bad_iv
      $error("IV_MAX out of range");
   end
   if (64'(LIM_PPB) >= (64'(1) << (PPB_W - 1))) begin : g_bad_lim
      $error("saturation limit does not fit the output width");
   end

   logic [GAIN_W-1:0]       kp_e, ki_e;
   logic [LW-1:0]           lg_c, l_q;
   logic                    clr, v1_q;
   logic signed [IV_W-1:0]  iv_c, iv_q;
   logic signed [OFS_W-1:0] avg;

   if (RUNTIME_CFG) begin : g_rt
      assign kp_e = kp_i;
      assign ki_e = ki_i;
      assign lg_c = (avg_log2_i > LW'(AVG_LMAX)) ? LW'(AVG_LMAX) : avg_log2_i;
   end else begin : g_fix
      logic unused_cfg;
      assign unused_cfg = ^{kp_i, ki_i, avg_log2_i};
      assign kp_e = GAIN_W'(KP);
      assign ki_e = GAIN_W'(KI);
      assign lg_c = LW'(AVG_LOG2);
   end

   always_comb begin
      if (log_intv_i > IVP)       iv_c = IV_W'(IV_MAX);
      else if (log_intv_i < -IVP) iv_c = -IV_W'(IV_MAX);
      else                        iv_c = IV_W'(log_intv_i);
   end

   assign clr = (lg_c != l_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         l_q       <= LW'(AVG_LOG2);
         v1_q      <= 1'b0;
         iv_q      <= '0;
         upd_o     <= 1'b0;
         filt_ns_o <= '0;
      end else begin
         l_q   <= lg_c;
         v1_q  <= ofs_stb_i;
         upd_o <= v1_q;
         if (ofs_stb_i) iv_q <= iv_c;
         if (v1_q)      filt_ns_o <= avg;
      end
   end

   ofs_avg_filter #(.OFS_W(OFS_W), .LMAX(AVG_LMAX)) filt_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .stb_i(ofs_stb_i),
      .ofs_i(ofs_ns_i), .lg_i(l_q), .avg_o(avg));

   pi_core #(.OFS_W(OFS_W), .PPB_W(PPB_W), .GAIN_W(GAIN_W), .FRAC_SH(FRAC_SH),
             .IV_MAX(IV_MAX), .LIM_PPB(LIM_PPB)) pi_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .go_i(v1_q), .avg_i(avg), .iv_i(iv_q),
      .kp_i(kp_e), .ki_i(ki_e), .ppb_o(freq_ppb_o));

   lock_det #(.OFS_W(OFS_W), .LOCK_NS(LOCK_NS), .UNLOCK_NS(UNLOCK_NS)) lock_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .go_i(v1_q), .avg_i(avg), .locked_o(locked_o));

   // R3
   upd_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ofs_stb_i |-> ##2 upd_o);
   // R3
   filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_o |-> $stable(filt_ns_o));
endmodule

// File: tb/ofs_pi_servo_tb_top.sv
module servo_ref #(
   parameter int FRAC   = 8,
   parameter int IVM    = 7,
   parameter int LIM    = 500000,
   parameter int LOCKT  = 500,
   parameter int UNLOCKT = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  int   ofs,
   input  int   iv,
   input  int   kp,
   input  int   ki,
   input  int   lg,
   output int   e_ppb,
   output bit   e_upd,
   output bit   e_lock,
   output int   e_filt
);
   int     q[$];
   longint integ = 0;
   bit     pend = 0;
   longint pavg = 0;
   int     piv = 0;
   int     prev_lg = 0;

   function automatic longint scl(longint x, int s);
      return (s >= 0) ? (x <<< s) : (x >>> (-s));
   endfunction
   function automatic longint clip(longint x);
      if (x > LIM) return LIM;
      if (x < -LIM) return -LIM;
      return x;
   endfunction
   function automatic void fill(int n);
      q.delete();
      for (int k = 0; k < n; k++) q.push_back(0);
   endfunction

   initial begin
      e_ppb = 0; e_upd = 0; e_lock = 0; e_filt = 0;
   end

   always @(posedge clk) begin : mdl
      longint s, p, i, mag;
      if (!rst_n) begin
         fill(1 << lg);
         prev_lg = lg; integ = 0; pend = 0;
         e_ppb = 0; e_upd = 0; e_lock = 0; e_filt = 0;
      end else begin
         e_upd = 0;
         if (pend) begin
            p = scl(pavg * kp, piv) >>> FRAC;
            i = scl(pavg * ki, piv) >>> FRAC;
            integ = clip(integ + i);
            e_ppb = int'(clip(p + integ));
            e_filt = int'(pavg);
            e_upd = 1;
            mag = (pavg < 0) ? -pavg : pavg;
            if (!e_lock && mag < LOCKT) e_lock = 1;
            else if (e_lock && mag > UNLOCKT) e_lock = 0;
         end
         pend = 0;
         if (lg != prev_lg) begin
            fill(1 << lg);
            prev_lg = lg;
         end else if (stb) begin
            q.push_front(ofs);
            void'(q.pop_back());
            s = 0;
            foreach (q[k]) s += q[k];
            pavg = s >>> lg;
            pend = 1;
            piv = (iv > IVM) ? IVM : ((iv < -IVM) ? -IVM : iv);
         end
      end
   end
endmodule

module ofs_pi_servo_tb_top;
   logic clk = 0;
   logic rst_n = 0;
   logic stb = 0;
   int   ofs = 0;
   byte  iv = 0;
   logic [15:0] kp = 16'd64;
   logic [15:0] ki = 16'd16;
   logic [2:0]  lg = 3'd3;
   bit   done = 0;
   int   n_chk = 0;
   int   n_fail = 0;

   always #10 clk = ~clk;

   logic signed [31:0] ppb_r, filt_r, ppb_f, filt_f;
   logic upd_r, lock_r, upd_f, lock_f;
   int   e_ppb_r, e_filt_r, e_ppb_f, e_filt_f;
   bit   e_upd_r, e_lock_r, e_upd_f, e_lock_f;

   ofs_pi_servo #(.RUNTIME_CFG(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ofs_stb_i(stb), .ofs_ns_i(ofs),
      .log_intv_i(iv), .kp_i(kp), .ki_i(ki), .avg_log2_i(lg),
      .freq_ppb_o(ppb_r), .upd_o(upd_r), .locked_o(lock_r), .filt_ns_o(filt_r));

   ofs_pi_servo #(.RUNTIME_CFG(1'b0), .KP(64), .KI(16), .AVG_LOG2(3)) dut_fix_i (
      .clk_i(clk), .rst_ni(rst_n), .ofs_stb_i(stb), .ofs_ns_i(ofs),
      .log_intv_i(iv), .kp_i(kp), .ki_i(ki), .avg_log2_i(lg),
      .freq_ppb_o(ppb_f), .upd_o(upd_f), .locked_o(lock_f), .filt_ns_o(filt_f));

   servo_ref ref_r (.clk(clk), .rst_n(rst_n), .stb(stb), .ofs(ofs), .iv(int'(iv)),
      .kp(int'(kp)), .ki(int'(ki)), .lg(int'(lg)),
      .e_ppb(e_ppb_r), .e_upd(e_upd_r), .e_lock(e_lock_r), .e_filt(e_filt_r));

   servo_ref ref_f (.clk(clk), .rst_n(rst_n), .stb(stb), .ofs(ofs), .iv(int'(iv)),
      .kp(64), .ki(16), .lg(3),
      .e_ppb(e_ppb_f), .e_upd(e_upd_f), .e_lock(e_lock_f), .e_filt(e_filt_f));

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the behavioural models
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 ppb run-time", ppb_r, e_ppb_r);
         chk("R2 filt run-time", filt_r, e_filt_r);
         chk("R3 upd run-time", upd_r, e_upd_r);
         chk("R6 lock run-time", lock_r, e_lock_r);
         chk("R8 ppb fixed", ppb_f, e_ppb_f);
         chk("R8 filt fixed", filt_f, e_filt_f);
         chk("R8 upd fixed", upd_f, e_upd_f);
         chk("R8 lock fixed", lock_f, e_lock_f);
      end
   end

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic push(input int v);
      stb = 1; ofs = v;
      @(negedge clk);
      stb = 0;
      @(negedge clk);
   endtask

   task automatic idle2();
      repeat (2) @(negedge clk);
   endtask

   task automatic run_main();
      @(negedge clk);
      do_reset();
      // R1 reset state
      chk("R1 ppb", ppb_r, 0);
      chk("R1 filt", filt_r, 0);
      chk("R1 upd", upd_r, 0);
      chk("R1 lock", lock_r, 0);
      chk("R1 fixed ppb", ppb_f, 0);

      // R3 timing: strobe edge, then upd two edges later
      stb = 1; ofs = 100;
      @(negedge clk);
      stb = 0;
      chk("R3 no upd after one edge", upd_r, 0);
      @(negedge clk);
      chk("R3 upd after two edges", upd_r, 1);
      chk("R2 first average", filt_r, 12);
      chk("R6 lock on small offset", lock_r, 1);

      // R7 hysteresis
      for (int k = 0; k < 8; k++) push(3000);
      chk("R7 stays locked at 3000", lock_r, 1);
      for (int k = 0; k < 8; k++) push(6000);
      chk("R7 drops above 5000", lock_r, 0);
      chk("R2 steady average", filt_r, 6000);
      for (int k = 0; k < 8; k++) push(3000);
      chk("R7 stays unlocked at 3000", lock_r, 0);
      for (int k = 0; k < 8; k++) push(0);
      chk("R6 relock at 0", lock_r, 1);

      // R5 saturation
      for (int k = 0; k < 8; k++) push(2000000000);
      chk("R5 positive clamp", ppb_r, 500000);
      for (int k = 0; k < 16; k++) push(-2000000000);
      chk("R5 negative clamp", ppb_r, -500000);

      // R10 reset mid-run
      do_reset();
      chk("R10 ppb cleared", ppb_r, 0);
      chk("R10 lock cleared", lock_r, 0);
      push(8);
      chk("R10 history cleared", filt_r, 1);

      // R4 interval scaling, proportional only, depth 1
      lg = 3'd0; kp = 16'd256; ki = 16'd0; iv = 0;
      idle2();
      push(1234);
      chk("R4 unity gain", ppb_r, 1234);
      iv = 1; push(1234);
      chk("R4 interval +1", ppb_r, 2468);
      iv = -1; push(1234);
      chk("R4 interval -1", ppb_r, 617);
      iv = -3; push(1234);
      chk("R4 interval -3", ppb_r, 154);
      push(-1234);
      chk("R4 floor rounding negative", ppb_r, -155);

      // R11 interval clamp
      iv = 100; push(10);
      chk("R11 clamp +7", ppb_r, 1280);
      iv = -100; push(1000);
      chk("R11 clamp -7", ppb_r, 7);

      // R4 integral action
      iv = 0; kp = 16'd0; ki = 16'd256;
      push(50);
      chk("R4 integral step 1", ppb_r, 50);
      push(50);
      chk("R4 integral step 2", ppb_r, 100);

      // R2 and R9 depth change
      lg = 3'd2; idle2();
      push(4); push(8); push(12); push(16);
      chk("R2 depth 4 average", filt_r, 10);
      push(20);
      chk("R2 sliding window", filt_r, 14);
      lg = 3'd3; idle2();
      push(-3);
      chk("R9 history cleared on depth change", filt_r, -1);

      // R8 fixed variant ignores configuration inputs
      do_reset();
      lg = 3'd1; kp = 16'd1; ki = 16'd1; iv = 0;
      idle2();
      push(800);
      chk("R8 fixed depth used", filt_f, 100);
      chk("R8 fixed gains used", ppb_f, 31);
      chk("R9 run-time depth used", filt_r, 400);
      idle2();
   endtask

   initial begin
      fork
         run_main();
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog actual=timeout expected=completion");
         end
      join_any
      disable fork;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule